// File: doc/BRIEF.md
# Serial Debug Console Responder

This block sits on the device end of a full-duplex, bit-serial link. It gives a host a byte-wide debug console. The host selects the device and clocks sixteen bits through it, most significant bit first. The first four bits the host sends form a command. The device decodes that command as soon as the fourth bit arrives, and it uses the remaining twelve bit slots of the same frame to send a reply back.

Two small FIFOs connect the link to a console. The outbound FIFO holds characters that the host pushed. It presents them on a valid/ready byte stream. The inbound FIFO collects characters from the console through a second valid/ready stream, and the host pops them one frame at a time.

Within the frame, reply bits are described by their position in a 32-bit image. The first transferred bit is image bit 31 and the sixteenth is image bit 16. All link inputs are sampled on `clk` edges where `link_stb` is high.

Top module: `dbgb_responder`

## Requirements
- R1: A complete frame with command nibble 0x9 returns the 16-bit reply 0x0470, as image bits 31:16.
- R2: Command 0xC returns image bit 26 set when the outbound FIFO has room for a byte. It returns all zeros when that FIFO is full.
- R3: Command 0xB carries a byte in image bits 27:20. At the end of a complete frame, that byte enters the outbound FIFO. Bytes leave on `con_tx_data` in push order, one per cycle in which `con_tx_valid` and `con_tx_ready` are both high. Held data stays stable while the console is not ready.
- R4: A 0xB frame that completes while the outbound FIFO is full is dropped. No byte appears for it.
- R5: Command 0xD returns image bit 26 set when the inbound FIFO holds a byte, and zero otherwise.
- R6: Command 0xA returns image bit 27 set and the head byte in image bits 23:16 when the inbound FIFO holds data. The byte is removed when the frame completes. When the inbound FIFO is empty, the reply is all zeros and nothing changes.
- R7: `link_miso` is low while `link_sel` is low and during the first four bits of a frame (image bits 31:28).
- R8: A frame that is deselected before its sixteenth bit pushes nothing and pops nothing.
- R9: Any command nibble other than 0x9, 0xA, 0xB, 0xC and 0xD returns zeros and changes neither FIFO.
- R10: `con_rx_ready` is high exactly when the inbound FIFO is not full. Accepted console bytes are popped by the host in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_sel | input | 1 | Frame select from the host; a frame lasts while it is high |
| link_stb | input | 1 | One link bit is exchanged on this clock edge |
| link_mosi | input | 1 | Host-to-device bit |
| link_miso | output | 1 | Device-to-host reply bit |
| con_tx_data | output | 8 | Outbound character to the console |
| con_tx_valid | output | 1 | Outbound character available |
| con_tx_ready | input | 1 | Console accepts the outbound character |
| con_rx_data | input | 8 | Inbound character from the console |
| con_rx_valid | input | 1 | Inbound character offered |
| con_rx_ready | output | 1 | Inbound FIFO has room |

## Verification
The bound checker watches four things on every cycle:
- the reply line stays quiet while the device is deselected and during the command nibble;
- a held outbound character stays stable under back-pressure;
- pushes and pops occur only on a selected strobe;
- the inbound ready flag falls only after a console write.

The reply codes, the byte positions inside a frame, and the dropping of pushes into a full FIFO can only be shown by the scenario sequences. So can the way aborted and unknown frames leave both FIFOs untouched. The bench checks these through later status and pop frames and through a scoreboard on the console port.

// File: rtl/dbgb_pkg.sv
`timescale 1ns/1ps
package dbgb_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CMD_BITS   = 4;
    localparam int REPLY_W    = FRAME_BITS - CMD_BITS;
    localparam int BYTE_W     = 8;
    // pushed byte's LSB sits at this bit of the 16-bit frame word
    localparam int BYTE_LSB   = 4;
    localparam int SHIFT_W    = BYTE_LSB + BYTE_W - 1;

    typedef enum logic [CMD_BITS-1:0] {
        CMD_IDENT  = 4'h9,
        CMD_POP    = 4'hA,
        CMD_PUSH   = 4'hB,
        CMD_TXROOM = 4'hC,
        CMD_RXHAS  = 4'hD
    } cmd_e;

    typedef struct packed {
        logic              tx_room;
        logic              rx_has;
        logic [BYTE_W-1:0] rx_head;
    } fifo_stat_t;

    localparam logic [REPLY_W-1:0] IDENT_REPLY = 12'h470;

    // Reply bits following the command nibble; [11] is image bit 27.
    function automatic logic [REPLY_W-1:0] reply_bits(
        input logic [CMD_BITS-1:0] cmd,
        input fifo_stat_t          st
    );
        logic [REPLY_W-1:0] r;
        r = '0;
        case (cmd)
            CMD_IDENT:  r = IDENT_REPLY;
            CMD_TXROOM: r[10] = st.tx_room;
            CMD_RXHAS:  r[10] = st.rx_has;
            CMD_POP: begin
                r[11] = st.rx_has;
                if (st.rx_has) r[BYTE_W-1:0] = st.rx_head;
            end
            default:    r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dbgb_fifo.sv
`timescale 1ns/1ps
module dbgb_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr, rd_ptr;
    logic             wr_ok, rd_ok;

    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign empty   = (wr_ptr == rd_ptr);
    assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign rd_data = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

endmodule

// File: rtl/dbgb_frame.sv
`timescale 1ns/1ps
module dbgb_frame
    import dbgb_pkg::*;
#(
    parameter int CNT_W = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              stb,
    input  logic              mosi,
    input  fifo_stat_t        st,
    output logic              miso,
    output logic              push_req,
    output logic [BYTE_W-1:0] push_byte,
    output logic              pop_req,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_BITS - 1);

    logic [CNT_W-1:0]    cnt;
    logic [SHIFT_W-1:0]  shreg;
    logic [CMD_BITS-1:0] cmd_q;
    logic [REPLY_W-1:0]  img;
    logic [CMD_BITS-1:0] cmd_now;
    logic                take, done;

    assign take    = sel && stb && (cnt != CNT_FULL);
    assign done    = take && (cnt == CNT_LAST);
    assign cmd_now = {shreg[CMD_BITS-2:0], mosi};

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            cnt   <= '0;
            shreg <= '0;
            cmd_q <= '0;
            img   <= '0;
        end else if (take) begin
            cnt   <= cnt + 1'b1;
            shreg <= {shreg[SHIFT_W-2:0], mosi};
            if (cnt == CNT_CMD) begin
                cmd_q <= cmd_now;
                img   <= reply_bits(cmd_now, st);
            end else begin
                img   <= {img[REPLY_W-2:0], 1'b0};
            end
        end
    end

    assign miso      = sel && img[REPLY_W-1];
    assign push_req  = done && (cmd_q == CMD_PUSH);
    assign pop_req   = done && (cmd_q == CMD_POP);
    assign push_byte = shreg[SHIFT_W-1:BYTE_LSB-1];
    assign bit_cnt   = cnt;

endmodule

// File: rtl/dbgb_responder.sv
`timescale 1ns/1ps
module dbgb_responder
    import dbgb_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       link_sel,
    input  logic       link_stb,
    input  logic       link_mosi,
    output logic       link_miso,
    output logic [7:0] con_tx_data,
    output logic       con_tx_valid,
    input  logic       con_tx_ready,
    input  logic [7:0] con_rx_data,
    input  logic       con_rx_valid,
    output logic       con_rx_ready
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    fifo_stat_t        stat;
    logic              push_req, pop_req;
    logic [BYTE_W-1:0] push_byte, rx_head;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic [CNT_W-1:0]  bit_cnt;

    assign stat = '{tx_room: !tx_full, rx_has: !rx_empty, rx_head: rx_head};

    dbgb_frame #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst(rst), .sel(link_sel), .stb(link_stb), .mosi(link_mosi),
        .st(stat), .miso(link_miso), .push_req(push_req), .push_byte(push_byte),
        .pop_req(pop_req), .bit_cnt(bit_cnt)
    );

    dbgb_fifo #(.WIDTH(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .wr_en(push_req), .wr_data(push_byte),
        .rd_en(con_tx_ready), .rd_data(con_tx_data), .empty(tx_empty), .full(tx_full)
    );

    dbgb_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .wr_en(con_rx_valid), .wr_data(con_rx_data),
        .rd_en(pop_req), .rd_data(rx_head), .empty(rx_empty), .full(rx_full)
    );

    assign con_tx_valid = !tx_empty;
    assign con_rx_ready = !rx_full;

endmodule

// File: rtl/dbgb_checker.sv
`timescale 1ns/1ps
module dbgb_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             link_sel,
    input logic             link_stb,
    input logic             link_miso,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             con_tx_valid,
    input logic             con_tx_ready,
    input logic [7:0]       con_tx_data,
    input logic             con_rx_valid,
    input logic             con_rx_ready,
    input logic             push_req,
    input logic             pop_req
);
    // R7
    miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !link_sel |-> !link_miso);

    // R7
    miso_cmd_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (link_sel && bit_cnt < CNT_W'(4)) |-> !link_miso);

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (con_tx_valid && !con_tx_ready) |=> (con_tx_valid && $stable(con_tx_data)));

    // R8
    act_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req || pop_req) |-> (link_sel && link_stb));

    // R10
    rx_ready_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(con_rx_ready) |-> $past(con_rx_valid));

endmodule

bind dbgb_responder dbgb_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .link_sel(link_sel), .link_stb(link_stb),
    .link_miso(link_miso), .bit_cnt(bit_cnt), .con_tx_valid(con_tx_valid),
    .con_tx_ready(con_tx_ready), .con_tx_data(con_tx_data),
    .con_rx_valid(con_rx_valid), .con_rx_ready(con_rx_ready),
    .push_req(push_req), .pop_req(pop_req)
);

// File: tb/dbgb_responder_test.sv
`timescale 1ns/1ps
module dbgb_responder_test;
    localparam int TXD = 4;
    localparam int RXD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       link_sel = 1'b0, link_stb = 1'b0, link_mosi = 1'b0;
    logic       link_miso;
    logic [7:0] con_tx_data;
    logic       con_tx_valid;
    logic       con_tx_ready = 1'b0;
    logic [7:0] con_rx_data = 8'h00;
    logic       con_rx_valid = 1'b0;
    logic       con_rx_ready;

    int errs = 0;
    int checks = 0;
    bit finished = 0;
    int tx_model = 0;
    logic [7:0] exp_q[$];
    logic [15:0] rep;

    always #2 clk = ~clk;

    dbgb_responder #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) uut (
        .clk(clk), .rst(rst), .link_sel(link_sel), .link_stb(link_stb),
        .link_mosi(link_mosi), .link_miso(link_miso),
        .con_tx_data(con_tx_data), .con_tx_valid(con_tx_valid),
        .con_tx_ready(con_tx_ready), .con_rx_data(con_rx_data),
        .con_rx_valid(con_rx_valid), .con_rx_ready(con_rx_ready)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic frame(input logic [15:0] word, input int nbits, output logic [15:0] r);
        r = '0;
        @(negedge clk);
        link_sel = 1'b1;
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            link_stb  = 1'b1;
            link_mosi = word[15-k];
            #1;
            r[15-k] = link_miso;
        end
        @(negedge clk);
        link_stb = 1'b0; link_mosi = 1'b0; link_sel = 1'b0;
        @(negedge clk);
    endtask

    // driver: push a character and record it when the model says it fits
    task automatic push_char(input logic [7:0] b);
        logic [15:0] r;
        frame({4'hB, b, 4'h0}, 16, r);
        if (tx_model < TXD) begin
            exp_q.push_back(b);
            tx_model++;
        end
    endtask

    task automatic drain_tx();
        @(negedge clk);
        con_tx_ready = 1'b1;
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
        @(negedge clk); @(negedge clk);
        #1;
        check("R4 outbound empty after drain", {15'd0, con_tx_valid}, 16'd0);
        con_tx_ready = 1'b0;
        tx_model = 0;
    endtask

    task automatic console_send(input logic [7:0] b);
        @(negedge clk);
        con_rx_valid = 1'b1; con_rx_data = b;
        @(negedge clk);
        con_rx_valid = 1'b0;
    endtask

    // monitor: compare each outbound transfer with the scoreboard
    always @(negedge clk) begin
        #1;
        if (!rst && con_tx_ready && con_tx_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errs++;
                $display("FAIL R4 unexpected byte: got %h expected none", con_tx_data);
            end else begin
                check("R3 outbound order", {8'h00, con_tx_data}, {8'h00, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R3 reset tx_valid", {15'd0, con_tx_valid}, 16'd0);
        check("R10 reset rx_ready", {15'd0, con_rx_ready}, 16'd1);
        check("R7 reset miso", {15'd0, link_miso}, 16'd0);

        frame(16'h9000, 16, rep); check("R1 ident", rep, 16'h0470);
        frame(16'hC000, 16, rep); check("R2 tx room empty", rep, 16'h0400);
        frame(16'hD000, 16, rep); check("R5 rx empty", rep, 16'h0000);
        frame(16'hA000, 16, rep); check("R6 pop empty", rep, 16'h0000);
        frame(16'hD000, 16, rep); check("R6 still empty", rep, 16'h0000);

        push_char(8'h48);
        push_char(8'h5A);
        frame(16'hC000, 16, rep); check("R2 tx room partial", rep, 16'h0400);
        push_char(8'h11);
        push_char(8'h22);
        frame(16'hC000, 16, rep); check("R2 tx full", rep, 16'h0000);
        push_char(8'h99);  // R4: dropped
        drain_tx();

        // R8: aborted push leaves outbound empty
        frame({4'hB, 8'h77, 4'h0}, 10, rep);
        repeat (4) @(negedge clk);
        #1; check("R8 aborted push", {15'd0, con_tx_valid}, 16'd0);

        // R9: unknown command
        frame({4'h5, 8'h33, 4'h0}, 16, rep); check("R9 unknown reply", rep, 16'h0000);
        repeat (4) @(negedge clk);
        #1; check("R9 no push", {15'd0, con_tx_valid}, 16'd0);

        console_send(8'h3C);
        console_send(8'hA5);
        frame(16'hD000, 16, rep); check("R5 rx has", rep, 16'h0400);
        frame(16'hA000, 8, rep);  check("R8 aborted pop reply", rep, 16'h0800);
        frame(16'hA000, 16, rep); check("R6 pop first", rep, 16'h083C);
        frame(16'hF000, 16, rep); check("R9 unknown F", rep, 16'h0000);
        frame(16'hA000, 16, rep); check("R8 R9 pop second", rep, 16'h08A5);
        frame(16'hA000, 16, rep); check("R6 pop drained", rep, 16'h0000);

        for (int i = 1; i <= RXD; i++) console_send(8'(i));
        #1; check("R10 rx full ready", {15'd0, con_rx_ready}, 16'd0);
        console_send(8'hEE);
        for (int i = 1; i <= RXD; i++) begin
            frame(16'hA000, 16, rep);
            check("R10 rx order", rep, {8'h08, 8'(i)});
        end
        #1; check("R10 rx ready again", {15'd0, con_rx_ready}, 16'd1);
        frame(16'hA000, 16, rep); check("R10 overflow dropped", rep, 16'h0000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule